// File: doc/BRIEF.md
# Prioritized DSP Exception Controller

This block sits next to a small DSP core and decides, at each instruction boundary, whether the core must jump to an exception handler. It keeps one pending flag for each of eight exception levels and one external-interrupt request flag. It also looks at two enable bits in the core's status word. When a level is accepted, the block drives a vector address and asks the core to push its PC and status word onto the two return stacks. It then holds that level as the one in service until the core reports a return from interrupt.

Only one exception is in service at any time. Among the levels that are allowed, the highest-numbered pending one wins. The external-interrupt level has its own enable bit and does not need the global interrupt enable. Handlers sit two words apart. Level 0 belongs to the reset path and is never scanned. The core pipeline, the stacks and the instruction decode lie outside the block; it only exchanges single-cycle pulses with them.

Top module: `dsp_exc_ctrl`

## Requirements
- R1: After reset, all pending flags, the in-service flag and the external request flag are 0, and no take or push pulse is driven.
- R2: A 1 on bit n of `set_lvl_i` (n from 1 to 7) sets pending flag n at the next clock edge. Bit 0 of `set_lvl_i` has no effect, and `pending_o[0]` stays 0.
- R3: In a check cycle, the highest-numbered eligible pending level (from 7 down to 1) is taken, and at most one level is taken per cycle.
- R4: A take drives `take_o`, `push_pc_o` and `push_sr_o` high for that cycle only. `vector_o` equals the level times two, and the push data outputs equal `pc_i` and `sr_i` of that cycle.
- R5: A take clears that level's pending flag at the clock edge and records the level as in service on `active_o` and `active_lvl_o`. A set pulse on the same level in the same cycle leaves the flag set.
- R6: While a level is in service, no level is taken. A pulse on `rti_i` clears the in-service state at the clock edge, and blocked levels can be taken from the next check cycle on.
- R7: Levels other than the external-interrupt level are eligible only when bit 9 (0x0200) of `sr_i` is 1. The external-interrupt level (parameter `EXT_LVL`, default 4) is eligible whatever the value of bit 9.
- R8: In a check cycle where the external request flag is set and bit 11 (0x0800) of `sr_i` is 1, the pending flag of `EXT_LVL` is set and the request flag is cleared at the clock edge. That level can be taken from the next check cycle on. A new request pulse in the same cycle keeps the request flag set.
- R9: While bit 11 of `sr_i` is 0, the external request flag stays set and is tried again at later check cycles.
- R10: Levels are taken and external requests are raised only in cycles where `boundary_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_lvl_i | input | 8 | One pulse bit per level; sets that level's pending flag |
| ext_req_set_i | input | 1 | Pulse that sets the external-interrupt request flag |
| sr_i | input | 16 | Core status word; bit 9 is the global enable, bit 11 the external enable |
| boundary_i | input | 1 | Instruction-boundary strobe; a cycle where it is 1 is a check cycle |
| rti_i | input | 1 | Return-from-interrupt pulse from the core |
| pc_i | input | PCW | Current program counter |
| take_o | output | 1 | Exception accepted in this cycle |
| vector_o | output | PCW | Handler address, level times two (0 when no take) |
| push_pc_o | output | 1 | Request to push the PC onto the PC return stack |
| push_pc_data_o | output | PCW | PC value to push |
| push_sr_o | output | 1 | Request to push the status word onto the SR return stack |
| push_sr_data_o | output | 16 | Status word to push |
| pending_o | output | 8 | Pending flags |
| active_o | output | 1 | An exception is in service |
| active_lvl_o | output | 3 | Level in service |
| ext_req_o | output | 1 | External-interrupt request flag |

## Verification
Two kinds of event can fall in the same cycle: a take that clears a pending flag, and a source that sets the same flag in that cycle. The source is either a set pulse on the level being taken, or the raising of the external request while the external level is itself being taken. The bench arranges both in one check cycle. It judges the result by the pending flags seen after the edge: the flag must still be set, while the in-service level must show the level that was just taken. A return-from-interrupt that arrives in a check cycle is also provoked. The bench confirms that nothing is taken in that cycle and that the blocked level is taken in the following one.

// File: rtl/dsp_exc_pkg.sv
package dsp_exc_pkg;

  // Number of exception levels and the width of a level index.
  localparam int NLVL = 8;
  localparam int LVLW = $clog2(NLVL);

  // Status word layout as the controller reads it.
  localparam int SRW       = 16;
  localparam int SR_GIE    = 9;   // global interrupt enable
  localparam int SR_XIE    = 11;  // external interrupt enable

  typedef logic [NLVL-1:0] lvl_mask_t;
  typedef logic [LVLW-1:0] lvl_idx_t;

endpackage

// File: rtl/dsp_exc_rst_sync.sv
module dsp_exc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dsp_exc_pending.sv
module dsp_exc_pending
  import dsp_exc_pkg::*;
#(
  parameter int EXT_LVL = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  lvl_mask_t set_i,
  input  logic      raise_i,
  input  logic      clr_en_i,
  input  lvl_idx_t  clr_lvl_i,
  output lvl_mask_t pending_o
);

  lvl_mask_t pend_q, pend_d;
  lvl_mask_t clr_mask, raise_mask, set_mask;

  always_comb begin
    clr_mask   = '0;
    raise_mask = '0;
    if (clr_en_i) clr_mask[clr_lvl_i] = 1'b1;
    if (raise_i)  raise_mask[EXT_LVL] = 1'b1;
    // level 0 belongs to the reset path
    set_mask    = set_i & ~lvl_mask_t'(1);
    pend_d      = (pend_q & ~clr_mask) | set_mask | raise_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pending_o = pend_q;

endmodule

// File: rtl/dsp_exc_ext_req.sv
module dsp_exc_ext_req
  import dsp_exc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_set_i,
  input  logic check_i,
  input  logic xie_i,
  output logic raise_o,
  output logic req_o
);

  logic req_q, req_d;

  always_comb begin
    raise_o = check_i & xie_i & req_q;
    req_d   = req_q;
    if (raise_o)   req_d = 1'b0;
    if (req_set_i) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

endmodule

// File: rtl/dsp_exc_arbiter.sv
module dsp_exc_arbiter
  import dsp_exc_pkg::*;
#(
  parameter int EXT_LVL = 4
) (
  input  lvl_mask_t pending_i,
  input  logic      gie_i,
  input  logic      allow_i,
  output logic      hit_o,
  output lvl_idx_t  lvl_o
);

  lvl_mask_t eligible;

  // level 0 is never scanned; the external level bypasses the global enable
  for (genvar g = 0; g < NLVL; g++) begin : g_elig
    if (g == 0) begin : g_rst
      assign eligible[g] = 1'b0;
    end else if (g == EXT_LVL) begin : g_ext
      assign eligible[g] = pending_i[g];
    end else begin : g_gen
      assign eligible[g] = pending_i[g] & gie_i;
    end
  end

  always_comb begin
    hit_o = 1'b0;
    lvl_o = '0;
    for (int i = 1; i < NLVL; i++) begin
      if (eligible[i]) begin
        hit_o = allow_i;
        lvl_o = lvl_idx_t'(i);
      end
    end
  end

endmodule

// File: rtl/dsp_exc_ctrl.sv
module dsp_exc_ctrl
  import dsp_exc_pkg::*;
#(
  parameter int PCW     = 16,
  parameter int EXT_LVL = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] set_lvl_i,
  input  logic            ext_req_set_i,
  input  logic [SRW-1:0]  sr_i,
  input  logic            boundary_i,
  input  logic            rti_i,
  input  logic [PCW-1:0]  pc_i,
  output logic            take_o,
  output logic [PCW-1:0]  vector_o,
  output logic            push_pc_o,
  output logic [PCW-1:0]  push_pc_data_o,
  output logic            push_sr_o,
  output logic [SRW-1:0]  push_sr_data_o,
  output logic [NLVL-1:0] pending_o,
  output logic            active_o,
  output logic [LVLW-1:0] active_lvl_o,
  output logic            ext_req_o
);

  logic      rst_int_n;
  logic      raise;
  logic      hit;
  lvl_idx_t  hit_lvl;
  lvl_mask_t pend;
  logic      act_q, act_d;
  lvl_idx_t  act_lvl_q, act_lvl_d;
  logic      act_en;

  dsp_exc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dsp_exc_ext_req u_ext (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_set_i (ext_req_set_i),
    .check_i   (boundary_i),
    .xie_i     (sr_i[SR_XIE]),
    .raise_o   (raise),
    .req_o     (ext_req_o)
  );

  dsp_exc_pending #(.EXT_LVL(EXT_LVL)) u_pend (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .set_i     (set_lvl_i),
    .raise_i   (raise),
    .clr_en_i  (hit),
    .clr_lvl_i (hit_lvl),
    .pending_o (pend)
  );

  dsp_exc_arbiter #(.EXT_LVL(EXT_LVL)) u_arb (
    .pending_i (pend),
    .gie_i     (sr_i[SR_GIE]),
    .allow_i   (boundary_i & ~act_q),
    .hit_o     (hit),
    .lvl_o     (hit_lvl)
  );

  // in-service tracking: a take sets it, a return clears it
  always_comb begin
    act_en    = hit | rti_i;
    act_d     = act_q;
    act_lvl_d = act_lvl_q;
    if (rti_i) begin
      act_d = 1'b0;
    end
    if (hit) begin
      act_d     = 1'b1;
      act_lvl_d = hit_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      act_q     <= 1'b0;
      act_lvl_q <= '0;
    end else if (act_en) begin
      act_q     <= act_d;
      act_lvl_q <= act_lvl_d;
    end
  end

  assign take_o         = hit;
  assign vector_o       = hit ? (PCW'(hit_lvl) << 1) : '0;
  assign push_pc_o      = hit;
  assign push_pc_data_o = pc_i;
  assign push_sr_o      = hit;
  assign push_sr_data_o = sr_i;
  assign pending_o      = pend;
  assign active_o       = act_q;
  assign active_lvl_o   = act_lvl_q;

endmodule

// File: rtl/dsp_exc_ctrl_chk.sv
module dsp_exc_ctrl_chk
  import dsp_exc_pkg::*;
#(
  parameter int PCW     = 16,
  parameter int EXT_LVL = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NLVL-1:0] set_lvl_i,
  input logic            ext_req_set_i,
  input logic [SRW-1:0]  sr_i,
  input logic            boundary_i,
  input logic            take_o,
  input logic [PCW-1:0]  vector_o,
  input logic [NLVL-1:0] pending_o,
  input logic            active_o,
  input logic [LVLW-1:0] active_lvl_o,
  input logic            ext_req_o
);

  AST_LVL0_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_o[0]);  // R2

  AST_VECTOR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vector_o[0] == 1'b0) && (vector_o != '0) && (vector_o < PCW'(2*NLVL)));  // R4

  AST_TAKE_RECORDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> active_o && (active_lvl_o == $past(vector_o[LVLW:1])));  // R5

  AST_NO_TAKE_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !take_o);  // R6

  AST_GIE_GATES_GENERAL: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !sr_i[SR_GIE]) |-> (vector_o == PCW'(2*EXT_LVL)));  // R7

  AST_EXT_REQ_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && ext_req_o && sr_i[SR_XIE] && !ext_req_set_i) |=>
      (!ext_req_o && pending_o[EXT_LVL]));  // R8

  AST_EXT_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req_o && !sr_i[SR_XIE]) |=> ext_req_o);  // R9

  AST_TAKE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> boundary_i);  // R10

endmodule

bind dsp_exc_ctrl dsp_exc_ctrl_chk #(.PCW(PCW), .EXT_LVL(EXT_LVL)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .set_lvl_i     (set_lvl_i),
  .ext_req_set_i (ext_req_set_i),
  .sr_i          (sr_i),
  .boundary_i    (boundary_i),
  .take_o        (take_o),
  .vector_o      (vector_o),
  .pending_o     (pending_o),
  .active_o      (active_o),
  .active_lvl_o  (active_lvl_o),
  .ext_req_o     (ext_req_o)
);

// File: tb/dsp_exc_ctrl_tb_top.sv
module dsp_exc_ctrl_tb_top;

  localparam int PCW = 16;

  logic        clk;
  logic        rst_n;
  logic [7:0]  set_lvl_i;
  logic        ext_req_set_i;
  logic [15:0] sr_i;
  logic        boundary_i;
  logic        rti_i;
  logic [15:0] pc_i;
  logic        take_o;
  logic [15:0] vector_o;
  logic        push_pc_o;
  logic [15:0] push_pc_data_o;
  logic        push_sr_o;
  logic [15:0] push_sr_data_o;
  logic [7:0]  pending_o;
  logic        active_o;
  logic [2:0]  active_lvl_o;
  logic        ext_req_o;

  int n_chk = 0;
  int n_bad = 0;

  dsp_exc_ctrl #(.PCW(PCW), .EXT_LVL(4)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .set_lvl_i      (set_lvl_i),
    .ext_req_set_i  (ext_req_set_i),
    .sr_i           (sr_i),
    .boundary_i     (boundary_i),
    .rti_i          (rti_i),
    .pc_i           (pc_i),
    .take_o         (take_o),
    .vector_o       (vector_o),
    .push_pc_o      (push_pc_o),
    .push_pc_data_o (push_pc_data_o),
    .push_sr_o      (push_sr_o),
    .push_sr_data_o (push_sr_data_o),
    .pending_o      (pending_o),
    .active_o       (active_o),
    .active_lvl_o   (active_lvl_o),
    .ext_req_o      (ext_req_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  typedef struct packed {
    logic [7:0]  set;
    logic        ext;
    logic [15:0] sr;
    logic        bnd;
    logic        rti;
    logic [15:0] pc;
    logic        take;
    logic [15:0] vec;
    logic [7:0]  pend;
    logic        act;
    logic        req;
  } vec_t;

  localparam int NV = 18;
  // inputs | expected take and vector in the cycle | state after the edge
  localparam vec_t TBL [NV] = '{
    '{8'h06, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0010, 1'b0, 16'h0000, 8'h06, 1'b0, 1'b0}, // R2 set
    '{8'h00, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0011, 1'b0, 16'h0000, 8'h06, 1'b0, 1'b0}, // R7 no GIE
    '{8'h00, 1'b0, 16'h0200, 1'b1, 1'b0, 16'h0100, 1'b1, 16'h0004, 8'h02, 1'b1, 1'b0}, // R3 take 2
    '{8'h80, 1'b0, 16'h0200, 1'b1, 1'b0, 16'h0101, 1'b0, 16'h0000, 8'h82, 1'b1, 1'b0}, // R6 blocked
    '{8'h00, 1'b0, 16'h0200, 1'b1, 1'b1, 16'h0102, 1'b0, 16'h0000, 8'h82, 1'b0, 1'b0}, // R6 rti cycle
    '{8'h00, 1'b0, 16'h0200, 1'b1, 1'b0, 16'h0103, 1'b1, 16'h000E, 8'h02, 1'b1, 1'b0}, // R3 take 7
    '{8'h00, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0104, 1'b0, 16'h0000, 8'h02, 1'b0, 1'b0}, // R6 rti
    '{8'h00, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0105, 1'b0, 16'h0000, 8'h02, 1'b0, 1'b1}, // R8 request
    '{8'h00, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0106, 1'b0, 16'h0000, 8'h02, 1'b0, 1'b1}, // R9 held
    '{8'h00, 1'b0, 16'h0800, 1'b1, 1'b0, 16'h0107, 1'b0, 16'h0000, 8'h12, 1'b0, 1'b0}, // R8 raise
    '{8'h00, 1'b0, 16'h0800, 1'b1, 1'b0, 16'h0108, 1'b1, 16'h0008, 8'h02, 1'b1, 1'b0}, // R7 ext bypass
    '{8'h00, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0109, 1'b0, 16'h0000, 8'h02, 1'b0, 1'b0}, // R6 rti
    '{8'h01, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h010A, 1'b0, 16'h0000, 8'h02, 1'b0, 1'b0}, // R2 level 0
    '{8'h02, 1'b0, 16'h0200, 1'b1, 1'b0, 16'h010B, 1'b1, 16'h0002, 8'h02, 1'b1, 1'b0}, // R5 set+take
    '{8'h00, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h010C, 1'b0, 16'h0000, 8'h02, 1'b0, 1'b0}, // R6 rti
    '{8'h08, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h010D, 1'b0, 16'h0000, 8'h0A, 1'b0, 1'b0}, // R2 set 3
    '{8'h00, 1'b0, 16'h0200, 1'b0, 1'b0, 16'h010E, 1'b0, 16'h0000, 8'h0A, 1'b0, 1'b0}, // R10 no strobe
    '{8'h00, 1'b0, 16'h0200, 1'b1, 1'b0, 16'h010F, 1'b1, 16'h0006, 8'h02, 1'b1, 1'b0}  // R3 take 3
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    set_lvl_i     = v.set;
    ext_req_set_i = v.ext;
    sr_i          = v.sr;
    boundary_i    = v.bnd;
    rti_i         = v.rti;
    pc_i          = v.pc;
  endtask

  // drive after a falling edge, judge the cycle's pulses, then the state after the edge
  task automatic apply(input vec_t v, input string tag);
    @(negedge clk);
    drive(v);
    #1;
    chk({tag, " take"}, 16'(take_o), 16'(v.take));
    chk({tag, " vector"}, vector_o, v.vec);
    chk({tag, " push_pc"}, 16'(push_pc_o), 16'(v.take));
    chk({tag, " push_sr"}, 16'(push_sr_o), 16'(v.take));
    @(posedge clk);
    #1;
    chk({tag, " pending"}, 16'(pending_o), 16'(v.pend));
    chk({tag, " active"}, 16'(active_o), 16'(v.act));
    chk({tag, " ext_req"}, 16'(ext_req_o), 16'(v.req));
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive('0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pending", 16'(pending_o), 16'h0000);
    chk("R1 reset active", 16'(active_o), 16'h0000);
    chk("R1 reset ext_req", 16'(ext_req_o), 16'h0000);
    chk("R1 reset take", 16'(take_o), 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i], $sformatf("vec%0d", i));
    end

    // leave service, then post a request
    apply('{8'h00, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 8'h02, 1'b0, 1'b0}, "R6 rti");
    apply('{8'h00, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'h02, 1'b0, 1'b1}, "R8 post");
    // raise and a new request in one check cycle: request stays set
    apply('{8'h00, 1'b1, 16'h0800, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 8'h12, 1'b0, 1'b1}, "R8 raise+set");
    // take level 4 while the request raises level 4 again; push data follows pc_i and sr_i
    @(negedge clk);
    drive('{8'h00, 1'b0, 16'h0A00, 1'b1, 1'b0, 16'h1234, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0});
    #1;
    chk("R3 take 4 over 1", vector_o, 16'h0008);
    chk("R4 pc push data", push_pc_data_o, 16'h1234);
    chk("R4 sr push data", push_sr_data_o, 16'h0A00);
    @(posedge clk);
    #1;
    chk("R5 raise keeps pending", 16'(pending_o), 16'h0012);
    chk("R5 level in service", 16'(active_lvl_o), 16'h0004);
    chk("R8 request consumed", 16'(ext_req_o), 16'h0000);
    // pulses last one cycle only
    @(negedge clk);
    drive('0);
    #1;
    chk("R4 single pulse", 16'(take_o), 16'h0000);

    // reset in the middle of service
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset pending", 16'(pending_o), 16'h0000);
    chk("R1 mid reset active", 16'(active_o), 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule